// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block holds the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). It looks at the source register numbers of the instruction in execute and compares them with the destination registers held in the memory and write-back stage registers. From that it picks the operand source for each execute input. It needs no clock because every output is a combinational function of the current pipeline contents. The surrounding datapath samples the outputs at its own clock edge.

A load still in the memory stage cannot supply its data to the instruction behind it. In that case the block holds fetch, decode and execute for one cycle, and a bubble enters the memory stage in place of the held instruction. On the next cycle the load sits in write-back and its value is forwarded into execute. Branches are resolved in execute but redirect fetch only from the memory stage. A taken branch therefore squashes the three younger instructions in fetch, decode and execute. A squash always wins over a stall. A squashed slot carries no register write and no memory write. A write-back that lands on a register being read in decode in the same cycle is also bypassed to the decode read.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: An execute source select (`fwd_a` for source 1, `fwd_b` for source 2) is 2'b01 (memory stage value) when the memory stage writes a register (`mem_we`=1), is not a load, and its destination equals that nonzero source number.
- R2: A select is 2'b10 (write-back value) when the write-back stage writes a nonzero register equal to the source and the memory stage does not supply it under R1.
- R3: When both the memory and write-back stages match a source under R1 and R2, the select is 2'b01. The younger memory-stage value wins.
- R4: A select is 2'b00 (register file value) when the source is register 0 or no stage matches, whatever the stage destinations are.
- R5: A load in memory (`mem_load`=1, `mem_we`=1) whose nonzero destination equals either execute source sets `hold_if`, `hold_id` and `hold_ex` and bubbles the memory stage (`kill_mem`=1). Otherwise, with no branch taken, all four are 0.
- R6: After a load-use stall, the load is in write-back, and a matching execute source selects 2'b10.
- R7: A taken branch in the memory stage (`br_taken`=1) sets `kill_id`, `kill_ex` and `kill_mem`, squashing the instructions in fetch, decode and execute.
- R8: With `br_taken`=1 the holds are 0 even when a load-use case is present. The squash wins over the stall.
- R9: `nxt_we` and `nxt_memwr` equal the execute instruction's `ex_we` and `ex_memwr` when `kill_mem`=0, and are 0 when `kill_mem`=1.
- R10: `byp_a` / `byp_b` are 1 when the write-back stage writes a nonzero register equal to decode source 1 / 2. Otherwise they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | Source 1 register of the instruction in execute |
| ex_rs2 | input | 5 | Source 2 register of the instruction in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_memwr | input | 1 | Execute instruction writes memory |
| id_rs1 | input | 5 | Source 1 register read in decode |
| id_rs2 | input | 5 | Source 2 register read in decode |
| mem_rd | input | 5 | Destination register in memory stage |
| mem_we | input | 1 | Memory stage instruction writes a register |
| mem_load | input | 1 | Memory stage instruction is a load |
| wb_rd | input | 5 | Destination register in write-back stage |
| wb_we | input | 1 | Write-back stage instruction writes a register |
| br_taken | input | 1 | Branch in memory stage is taken |
| fwd_a | output | 2 | Execute source 1 select (00 regfile, 01 memory, 10 write-back) |
| fwd_b | output | 2 | Execute source 2 select (same encoding) |
| byp_a | output | 1 | Decode source 1 takes the write-back value |
| byp_b | output | 1 | Decode source 2 takes the write-back value |
| hold_if | output | 1 | Hold the fetch address |
| hold_id | output | 1 | Hold the fetch/decode register |
| hold_ex | output | 1 | Hold the decode/execute register |
| kill_id | output | 1 | Squash the instruction entering decode |
| kill_ex | output | 1 | Squash the instruction entering execute |
| kill_mem | output | 1 | Bubble into the memory stage |
| nxt_we | output | 1 | Register write control passed to memory stage |
| nxt_memwr | output | 1 | Memory write control passed to memory stage |

## Verification
The assertions check several properties whenever the inputs change. Register 0 is never forwarded. A select of 01 or 10 always points at a stage that really writes that register. A hold always comes with a bubble, and a taken branch always clears the holds. A killed slot never passes on a write control. Only the bench scenarios can show the exact select under both-stage priority and the follow-on cycle after a load-use stall, where the load has moved to write-back. The same goes for the decode bypass against each decode source.

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic          ex_we,
  input  logic          ex_memwr,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          br_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          byp_a,
  output logic          byp_b,
  output logic          hold_if,
  output logic          hold_id,
  output logic          hold_ex,
  output logic          kill_id,
  output logic          kill_ex,
  output logic          kill_mem,
  output logic          nxt_we,
  output logic          nxt_memwr
);
  localparam logic [RW-1:0] ZERO = '0;
  localparam logic [1:0] SEL_RF = 2'b00, SEL_MEM = 2'b01, SEL_WB = 2'b10;

  logic mem_alu_wr, mem_ld_wr, wb_wr;
  logic mem_a, mem_b, wb_a, wb_b, ld_use;

  assign mem_alu_wr = mem_we && !mem_load && mem_rd != ZERO;
  assign mem_ld_wr  = mem_we && mem_load && mem_rd != ZERO;
  assign wb_wr      = wb_we && wb_rd != ZERO;

  assign mem_a = mem_alu_wr && mem_rd == ex_rs1;
  assign mem_b = mem_alu_wr && mem_rd == ex_rs2;
  assign wb_a  = wb_wr && wb_rd == ex_rs1;
  assign wb_b  = wb_wr && wb_rd == ex_rs2;

  assign fwd_a = mem_a ? SEL_MEM : (wb_a ? SEL_WB : SEL_RF);
  assign fwd_b = mem_b ? SEL_MEM : (wb_b ? SEL_WB : SEL_RF);

  assign byp_a = wb_wr && wb_rd == id_rs1;
  assign byp_b = wb_wr && wb_rd == id_rs2;

  assign ld_use = mem_ld_wr && (mem_rd == ex_rs1 || mem_rd == ex_rs2);

  assign hold_if  = ld_use && !br_taken;
  assign hold_id  = hold_if;
  assign hold_ex  = hold_if;
  assign kill_id  = br_taken;
  assign kill_ex  = br_taken;
  assign kill_mem = br_taken || ld_use;

  assign nxt_we    = ex_we && !kill_mem;
  assign nxt_memwr = ex_memwr && !kill_mem;
endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] ex_rs1,
  input logic [RW-1:0] ex_rs2,
  input logic          ex_we,
  input logic          ex_memwr,
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] id_rs2,
  input logic [RW-1:0] mem_rd,
  input logic          mem_we,
  input logic          mem_load,
  input logic [RW-1:0] wb_rd,
  input logic          wb_we,
  input logic          br_taken,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          byp_a,
  input logic          byp_b,
  input logic          hold_if,
  input logic          hold_id,
  input logic          hold_ex,
  input logic          kill_id,
  input logic          kill_ex,
  input logic          kill_mem,
  input logic          nxt_we,
  input logic          nxt_memwr
);
  always_comb begin
    // R4
    zero_src_fwd_chk: assert (ex_rs1 != '0 || fwd_a == 2'b00);
    // R1
    mem_src_valid_chk: assert (fwd_a != 2'b01 || (mem_we && !mem_load && mem_rd == ex_rs1));
    // R2
    wb_src_valid_chk: assert (fwd_b != 2'b10 || (wb_we && wb_rd == ex_rs2 && wb_rd != '0));
    // R5
    hold_bubble_chk: assert (!(hold_if || hold_id || hold_ex) || kill_mem);
    // R8
    flush_wins_chk: assert (!br_taken || !(hold_if || hold_id || hold_ex));
    // R7
    flush_all_chk: assert (!br_taken || (kill_id && kill_ex && kill_mem));
    // R9
    kill_ctrl_chk: assert (!kill_mem || (!nxt_we && !nxt_memwr));
    // R10
    byp_zero_chk: assert (id_rs1 != '0 || !byp_a);
  end
endmodule

bind hazard_fwd_ctrl hazard_fwd_chk #(.RW(RW)) u_chk (.*);

// File: tb/hazard_fwd_ctrl_tb.sv
module hazard_fwd_ctrl_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [4:0] ex_rs1, ex_rs2, id_rs1, id_rs2, mem_rd, wb_rd;
  logic ex_we, ex_memwr, mem_we, mem_load, wb_we, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic byp_a, byp_b, hold_if, hold_id, hold_ex, kill_id, kill_ex, kill_mem, nxt_we, nxt_memwr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  hazard_fwd_ctrl u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_rs1 = 0; ex_rs2 = 0; ex_we = 0; ex_memwr = 0; id_rs1 = 0; id_rs2 = 0;
    mem_rd = 0; mem_we = 0; mem_load = 0; wb_rd = 0; wb_we = 0; br_taken = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    idle(); settle();
    chk("R4 idle fwd_a", fwd_a, 0);
    chk("R5 idle holds", {hold_if, hold_id, hold_ex, kill_mem}, 0);
    chk("R7 idle kills", {kill_id, kill_ex}, 0);
  endtask

  task automatic t_mem_fwd();
    idle(); ex_rs1 = 3; ex_rs2 = 7; mem_rd = 3; mem_we = 1; settle();
    chk("R1 fwd_a mem", fwd_a, 1);
    chk("R4 fwd_b none", fwd_b, 0);
    mem_rd = 7; settle();
    chk("R1 fwd_b mem", fwd_b, 1);
    chk("R1 fwd_a none", fwd_a, 0);
  endtask

  task automatic t_wb_fwd();
    idle(); ex_rs1 = 9; ex_rs2 = 9; wb_rd = 9; wb_we = 1; settle();
    chk("R2 fwd_a wb", fwd_a, 2);
    chk("R2 fwd_b wb", fwd_b, 2);
    wb_we = 0; settle();
    chk("R2 no we", fwd_a, 0);
  endtask

  task automatic t_priority();
    idle(); ex_rs1 = 12; ex_rs2 = 5; mem_rd = 12; mem_we = 1; wb_rd = 12; wb_we = 1; settle();
    chk("R3 mem beats wb", fwd_a, 1);
    mem_rd = 5; wb_rd = 5; settle();
    chk("R3 mem beats wb b", fwd_b, 1);
  endtask

  task automatic t_zero();
    idle(); mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1; settle();
    chk("R4 r0 fwd_a", fwd_a, 0);
    chk("R4 r0 fwd_b", fwd_b, 0);
    id_rs1 = 0; settle();
    chk("R10 r0 no bypass", byp_a, 0);
  endtask

  task automatic t_load_use();
    idle(); ex_rs2 = 6; ex_we = 1; ex_memwr = 1; mem_rd = 6; mem_we = 1; mem_load = 1; settle();
    chk("R5 hold_if", hold_if, 1);
    chk("R5 hold_id", hold_id, 1);
    chk("R5 hold_ex", hold_ex, 1);
    chk("R5 bubble", kill_mem, 1);
    chk("R5 no load fwd", fwd_b, 0);
    chk("R9 bubble we", nxt_we, 0);
    chk("R9 bubble memwr", nxt_memwr, 0);
    // next cycle: load in write-back, consumer still in execute
    idle(); ex_rs2 = 6; ex_we = 1; wb_rd = 6; wb_we = 1; settle();
    chk("R6 wb fwd after stall", fwd_b, 2);
    chk("R5 stall released", hold_if, 0);
    chk("R9 pass we", nxt_we, 1);
    idle(); ex_rs1 = 4; mem_rd = 6; mem_we = 1; mem_load = 1; settle();
    chk("R5 no match no stall", kill_mem, 0);
  endtask

  task automatic t_flush();
    idle(); br_taken = 1; ex_memwr = 1; settle();
    chk("R7 kill_id", kill_id, 1);
    chk("R7 kill_ex", kill_ex, 1);
    chk("R7 kill_mem", kill_mem, 1);
    chk("R9 flush memwr", nxt_memwr, 0);
    ex_rs1 = 8; mem_rd = 8; mem_we = 1; mem_load = 1; settle();
    chk("R8 flush over stall", {hold_if, hold_id, hold_ex}, 0);
    chk("R8 still killed", kill_mem, 1);
  endtask

  task automatic t_bypass();
    idle(); id_rs1 = 17; id_rs2 = 18; wb_rd = 17; wb_we = 1; settle();
    chk("R10 byp_a", byp_a, 1);
    chk("R10 byp_b", byp_b, 0);
    wb_rd = 18; settle();
    chk("R10 byp_b hit", byp_b, 1);
    chk("R10 byp_a miss", byp_a, 0);
  endtask

  initial begin
    t_reset_state();
    t_mem_fwd();
    t_wb_fwd();
    t_priority();
    t_zero();
    t_load_use();
    t_flush();
    t_bypass();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule